// File: doc/BRIEF.md
# Timer Output Compare Channel

An 8-bit count register with one compare channel: an active compare register, an equality comparator, a sticky compare flag for interrupt requests, and a driver for a waveform pin. The counter runs in one of four modes: free-running wrap, clear-on-compare, single-slope PWM and dual-slope (up/down) PWM. It advances only on cycles where the timer clock-enable input `tick` is high.

A host writes the count, the compare value and a control byte through strobed write ports that share one data bus. In the two PWM modes a compare write lands in a shadow register. The active compare value is taken from the shadow only at one fixed point of the count sequence, so every PWM period uses a single threshold. In the two non-PWM modes compare writes take effect at once. A force strobe can drive the pin as if a compare had hit. Writing the count masks any compare hit on the next timer tick, so a count equal to the compare value can be loaded without raising the flag.

Top module: `tmr_oc_top`

## Requirements
- R1: After synchronous reset, `count` is 0, `wave` is 0 and `flag` is 0. The mode is wrap, the pin setting is 00 and both compare registers are 0.
- R2: In wrap mode (mode code 00), every tick adds one to `count`, and 255 rolls over to 0. On a cycle with `tick` low and no count write, `count` holds.
- R3: In clear-on-compare mode (code 01), a tick on which the compare hits sets `count` to 0. Other ticks add one.
- R4: In dual-slope mode (code 11), `count` climbs to 255 and then falls one per tick to 0. Each turning value appears for exactly one tick.
- R5: A compare hit on a tick sets `flag` on the next cycle. `flag` stays set until `flag_clr` is pulsed. A hit in the same cycle as `flag_clr` leaves `flag` set.
- R6: The control write takes the mode from `wr_data[1:0]` and the pin setting from `wr_data[3:2]`. Pin settings are 00 = pin held low, 01 = toggle, 10 = drive low, 11 = drive high. In wrap and clear-on-compare modes, the action is applied on each compare hit.
- R7: `force_cmp` applies the pin action of R6 only in modes 00 and 01. It never sets `flag` and never changes `count`. In modes 10 and 11 it has no effect on the pin.
- R8: A count write loads `wr_data` into `count` and masks compare hits on the next tick, even if `tick` stays low for many cycles in between.
- R9: In modes 00 and 01, a compare write changes the active compare value on the next cycle.
- R10: In single-slope mode (code 10), `count` wraps from 255 to 0, and the shadow compare value becomes active on the wrap tick. Pin setting 10 drives high on the wrap tick and low on a hit. Setting 11 is the inverse. When both occur on the same tick, the wrap action wins. Settings 00 and 01 hold the pin low.
- R11: In dual-slope mode, the shadow compare value becomes active on the tick at 255 while climbing. Pin setting 10 drives low on a hit while climbing and high on the tick at 0 while falling. Setting 11 is the inverse. Hits while falling only set `flag`.
- R12: Compare hits are evaluated only on cycles with `tick` high. With `tick` low, an equal count and compare value set nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock-enable |
| wr_cnt | input | 1 | Load `wr_data` into the count |
| wr_cmp | input | 1 | Write `wr_data` as compare value |
| wr_ctl | input | 1 | Write mode and pin setting from `wr_data[3:0]` |
| wr_data | input | 8 | Shared write data |
| force_cmp | input | 1 | Forced compare strobe |
| flag_clr | input | 1 | Clear strobe for the compare flag |
| wave | output | 1 | Waveform pin |
| flag | output | 1 | Sticky compare flag |
| count | output | 8 | Current count |

## Verification
Directed sequences come first. They load a count equal to the compare value with the timer stopped and then stepped, hold `tick` low on an equal count, force the pin in a non-PWM mode and in a PWM mode, and raise a hit together with a clear. Together these separate masking, tick gating and force isolation. Every mode is then paired with every pin setting under random ticks and random count, compare and force writes. Compare values are biased toward 0 and 255, so the wrap-versus-hit ordering and the shadow load points are exercised often. A bench model predicts `count`, `wave` and `flag` on every cycle. A count mismatch separates the four counting sequences, and a pin mismatch separates immediate compare updates from shadowed ones.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

    typedef enum logic [1:0] {
        WGM_NORMAL = 2'b00,
        WGM_CTC    = 2'b01,
        WGM_FAST   = 2'b10,
        WGM_PHASE  = 2'b11
    } wgm_e;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'b00,
        PIN_TOGGLE = 2'b01,
        PIN_CLEAR  = 2'b10,
        PIN_SET    = 2'b11
    } pin_e;

    typedef struct packed {
        pin_e pin;
        wgm_e wgm;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef struct packed {
        logic top;
        logic bottom;
        logic up;
    } seq_evt_t;

    function automatic logic is_pwm(wgm_e w);
        return (w == WGM_FAST) || (w == WGM_PHASE);
    endfunction

    function automatic logic pin_apply(pin_e pm, logic cur);
        case (pm)
            PIN_TOGGLE: return !cur;
            PIN_CLEAR:  return 1'b0;
            PIN_SET:    return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter
    import tmr_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  wgm_e         wgm,
    input  logic         hit,
    output logic [W-1:0] count,
    output logic         blk,
    output seq_evt_t     evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_n;
    logic         up_q, up_n;
    logic         blk_q;
    logic         adv;

    assign adv = tick && !wr_cnt;

    always_comb begin
        cnt_n = cnt_q + ONE;
        up_n  = 1'b1;
        case (wgm)
            WGM_CTC:   if (hit) cnt_n = '0;
            WGM_PHASE: begin
                up_n = up_q;
                if (up_q) begin
                    if (cnt_q == MAXV) begin
                        cnt_n = MAXV - ONE;
                        up_n  = 1'b0;
                    end
                end else if (cnt_q == '0) begin
                    cnt_n = ONE;
                    up_n  = 1'b1;
                end else begin
                    cnt_n = cnt_q - ONE;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        evt.up     = up_q;
        evt.top    = adv && (wgm == WGM_PHASE) && up_q && (cnt_q == MAXV);
        evt.bottom = adv && (((wgm == WGM_FAST) && (cnt_q == MAXV)) ||
                             ((wgm == WGM_PHASE) && !up_q && (cnt_q == '0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
            blk_q <= 1'b0;
        end else if (wr_cnt) begin
            cnt_q <= wr_data;
            blk_q <= 1'b1;
        end else if (tick) begin
            cnt_q <= cnt_n;
            up_q  <= up_n;
            blk_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign blk   = blk_q;

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(cnt_q));
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && wgm == WGM_NORMAL && cnt_q == MAXV) |=> (cnt_q == '0));
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/tmr_oc_cmpreg.sv
module tmr_oc_cmpreg
    import tmr_oc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_data,
    input  wgm_e         wgm,
    input  logic         load,
    output logic [W-1:0] ocr
);
    logic [W-1:0] shadow_q, act_q;
    logic         pwm;

    assign pwm = is_pwm(wgm);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            if (wr_cmp) shadow_q <= wr_data;
            if (!pwm && wr_cmp)   act_q <= wr_data;
            else if (pwm && load) act_q <= shadow_q;
        end
    end

    assign ocr = act_q;

    p_direct_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_cmp && !pwm) |=> (act_q == $past(wr_data)));
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pwm && !load) |=> $stable(act_q));
endmodule

// File: rtl/tmr_oc_wave.sv
module tmr_oc_wave
    import tmr_oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ctl_t     ctl,
    input  logic     hit,
    input  seq_evt_t evt,
    input  logic     force_cmp,
    input  logic     flag_clr,
    output logic     wave,
    output logic     flag
);
    logic pin_q, pin_n, flag_q;
    logic pwm, hit_up, hi_lvl;

    assign pwm    = is_pwm(ctl.wgm);
    assign hit_up = hit && ((ctl.wgm == WGM_FAST) || evt.up);
    assign hi_lvl = (ctl.pin == PIN_CLEAR);

    always_comb begin
        pin_n = pin_q;
        if (ctl.pin == PIN_OFF) begin
            pin_n = 1'b0;
        end else if (!pwm) begin
            if (hit || force_cmp) pin_n = pin_apply(ctl.pin, pin_q);
        end else if (ctl.pin == PIN_TOGGLE) begin
            pin_n = 1'b0;
        end else if (evt.bottom) begin
            pin_n = hi_lvl;
        end else if (hit_up) begin
            pin_n = !hi_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (hit)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign wave = pin_q;
    assign flag = flag_q;

    p_flag_set_r5: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);
    p_pin_off_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.pin == PIN_OFF) |=> !pin_q);
    p_force_noflag_r7: assert property (@(posedge clk) disable iff (rst)
        (force_cmp && !hit && !flag_q) |=> !flag_q);
endmodule

// File: rtl/tmr_oc_top.sv
module tmr_oc_top
    import tmr_oc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_cmp,
    input  logic             wr_ctl,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             force_cmp,
    input  logic             flag_clr,
    output logic             wave,
    output logic             flag,
    output logic [CNT_W-1:0] count
);
    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt, ocr;
    logic             blk, hit, load;
    seq_evt_t         evt;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '{pin: PIN_OFF, wgm: WGM_NORMAL};
        else if (wr_ctl) ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
    end

    assign hit  = tick && !wr_cnt && !blk && (cnt == ocr);
    assign load = (ctl_q.wgm == WGM_FAST) ? evt.bottom : evt.top;

    tmr_oc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .wr_cnt(wr_cnt),
        .wr_data(wr_data), .wgm(ctl_q.wgm), .hit(hit),
        .count(cnt), .blk(blk), .evt(evt)
    );

    tmr_oc_cmpreg #(.W(CNT_W)) u_cmp (
        .clk(clk), .rst(rst), .wr_cmp(wr_cmp), .wr_data(wr_data),
        .wgm(ctl_q.wgm), .load(load), .ocr(ocr)
    );

    tmr_oc_wave u_wave (
        .clk(clk), .rst(rst), .ctl(ctl_q), .hit(hit), .evt(evt),
        .force_cmp(force_cmp), .flag_clr(flag_clr),
        .wave(wave), .flag(flag)
    );

    assign count = cnt;

    p_block_r8: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> !hit);
    p_tick_gate_r12: assert property (@(posedge clk) disable iff (rst)
        (!tick && !flag && !flag_clr) |=> !flag);
    p_force_count_r7: assert property (@(posedge clk) disable iff (rst)
        (force_cmp && !tick && !wr_cnt) |=> $stable(count));
endmodule

// File: tb/tmr_oc_top_test.sv
`timescale 1ns/1ps
module tmr_oc_top_test;
    logic       clk = 1'b0, rst = 1'b1;
    logic       tick = 0, wr_cnt = 0, wr_cmp = 0, wr_ctl = 0, force_cmp = 0, flag_clr = 0;
    logic [7:0] wr_data = 0;
    logic       wave, flag;
    logic [7:0] count;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    int m_cnt, m_ocr, m_shd, m_wgm, m_pm;
    bit m_up, m_blk, m_wave, m_flag;

    always #2 clk = ~clk;

    tmr_oc_top uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_cnt(wr_cnt), .wr_cmp(wr_cmp),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .force_cmp(force_cmp),
        .flag_clr(flag_clr), .wave(wave), .flag(flag), .count(count)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit pin_act(int pm, bit cur);
        if (pm == 1) return !cur;
        return pm == 3;
    endfunction

    task automatic model_step(bit t, bit wc, bit wp, bit wl, int d, bit f, bit c);
        bit adv = t && !wc;
        bit hitv = adv && !m_blk && (m_cnt == m_ocr);
        bit pwm = (m_wgm >= 2);
        bit top = adv && m_wgm == 3 && m_up && m_cnt == 255;
        bit bot = adv && ((m_wgm == 2 && m_cnt == 255) || (m_wgm == 3 && !m_up && m_cnt == 0));
        int ncnt = m_cnt; bit nup = m_up;
        if (m_pm == 0) m_wave = 0;
        else if (!pwm) begin
            if (hitv || f) m_wave = pin_act(m_pm, m_wave);
        end else if (m_pm == 1) m_wave = 0;
        else if (bot) m_wave = (m_pm == 2);
        else if (hitv && (m_wgm == 2 || m_up)) m_wave = (m_pm == 3);
        if (hitv) m_flag = 1; else if (c) m_flag = 0;
        if (!pwm && wp) m_ocr = d;
        else if (pwm && ((m_wgm == 2) ? bot : top)) m_ocr = m_shd;
        if (wp) m_shd = d;
        if (wc) begin ncnt = d; m_blk = 1; end
        else if (t) begin
            m_blk = 0;
            nup = 1;
            case (m_wgm)
                0, 2: ncnt = (m_cnt + 1) % 256;
                1: ncnt = hitv ? 0 : (m_cnt + 1) % 256;
                default: begin
                    nup = m_up;
                    if (m_up) begin
                        if (m_cnt == 255) begin ncnt = 254; nup = 0; end else ncnt = m_cnt + 1;
                    end else if (m_cnt == 0) begin ncnt = 1; nup = 1; end
                    else ncnt = m_cnt - 1;
                end
            endcase
        end
        m_cnt = ncnt; m_up = nup;
        if (wl) begin m_wgm = d & 3; m_pm = (d >> 2) & 3; end
    endtask

    task automatic cyc(bit t, bit wc, bit wp, bit wl, int d, bit f, bit c);
        tick = t; wr_cnt = wc; wr_cmp = wp; wr_ctl = wl; wr_data = d[7:0];
        force_cmp = f; flag_clr = c;
        model_step(t, wc, wp, wl, d, f, c);
        @(posedge clk);
        @(negedge clk);
        chk(m_wgm == 0 ? "R2 count" : m_wgm == 1 ? "R3 count" :
            m_wgm == 2 ? "R10 count" : "R4 count", count, m_cnt);
        chk(m_wgm < 2 ? "R6 wave" : m_wgm == 2 ? "R10 wave" : "R11 wave", wave, m_wave);
        chk("R5 flag", flag, m_flag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = 0; m_ocr = 0; m_shd = 0; m_wgm = 0; m_pm = 0;
        m_up = 1; m_blk = 0; m_wave = 0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 count", count, 0);
        chk("R1 wave", wave, 0);
        chk("R1 flag", flag, 0);

        // R8: count loaded equal to compare while stopped, first tick masked
        cyc(0, 0, 1, 0, 5, 0, 0);
        cyc(0, 1, 0, 0, 5, 0, 0);
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R8 masked flag", flag, 0);
        chk("R8 count after", count, 6);
        cyc(0, 1, 0, 0, 4, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R8 unmasked hit", flag, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R5 clear", flag, 0);

        // R12 / R9: equal values with tick low
        cyc(0, 0, 1, 0, 6, 0, 0);
        repeat (4) cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R12 no tick", flag, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R9 immediate compare", flag, 1);
        chk("R9 count", count, 7);
        cyc(0, 0, 0, 0, 0, 0, 1);

        // R7: force in wrap mode with toggle, then in dual-slope mode
        cyc(0, 0, 0, 1, 4'b0100, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 force pin", wave, 1);
        chk("R7 force flag", flag, 0);
        chk("R7 force count", count, 7);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 force toggle back", wave, 0);
        cyc(0, 0, 0, 1, 4'b1111, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7 force ignored in PWM", wave, 0);
        chk("R7 count unchanged", count, 7);

        // R5: hit together with clear
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 20, 0, 0);
        cyc(0, 0, 1, 0, 21, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 1);
        chk("R5 set beats clear", flag, 1);

        // R3: clear-on-compare
        cyc(0, 0, 0, 1, 4'b0001, 0, 0);
        cyc(0, 0, 1, 0, 3, 0, 0);
        cyc(0, 1, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R3 cleared on hit", count, 0);

        // R4: turn at the top
        cyc(0, 0, 0, 1, 4'b0011, 0, 0);
        cyc(0, 1, 0, 0, 254, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R4 reach top", count, 255);
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R4 turn down", count, 254);

        // every mode with every pin setting, random stimulus
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 4; p++) begin
                cyc(0, 0, 0, 1, (p << 2) | m, 0, 0);
                for (int i = 0; i < 1200; i++) begin
                    int sel = $urandom % 4;
                    int d = (sel == 0) ? 0 : (sel == 1) ? 255 : int'($urandom % 256);
                    cyc(($urandom % 10) < 8, ($urandom % 64) == 0, ($urandom % 32) == 0,
                        0, d, ($urandom % 32) == 0, ($urandom % 16) == 0);
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule